// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Register Bank

This block is a configuration register bank reached over a three-wire serial port: a serial clock, an active-low chip select, and one data line split into an input, an output and an output enable. Each transaction begins with a 16-bit instruction. The instruction carries a read/write flag, a byte count and a 13-bit register address. The data bytes follow the instruction, and the address steps once after each byte.

The charge-pump registers are double buffered. A serial write lands only in the buffer copy. The active copy, which drives the parallel outputs, is loaded from the buffer when software writes a self-clearing update bit. A readback selector chooses whether reads of buffered registers return the active or the pending value.

A configuration byte holds four things:
- the serial bit and byte order;
- a self-clearing soft reset;
- two fixed mode bits;
- a mirror of its upper nibble in its lower nibble.

The serial inputs are oversampled by the block clock, so the serial clock must run well below the block clock.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset the outputs are at their defaults. `cp_current_o` equals `pin_cp_i`. `cp_mode_o` is 2'b11. `fb_neg_edge_o`, `ref_neg_edge_o`, `vco_mid_o`, `abl_manual_o` and `sdo_oe` are 0. The registers read as: 0x00 reads 0x11, 0x0A reads 0x80, 0x0B reads 0x30, and 0x04 reads 0x00.
- R2: A transaction opens when `cs_n` goes low and ends when it goes high. Instruction bit 15 is the read flag (1 = read). Bits 14:13 hold the byte count minus one. Bits 12:0 hold the address. `sdi` is captured on the rising edge of `sclk`. `sdo` changes after the falling edge of `sclk`, and `sdo_oe` is high only while read data is being driven.
- R3: Writes to 0x0A and 0x0B change only the buffered copies, and the outputs keep their values. Writing 1 to bit 0 of register 0x05 loads every active copy from its buffer. Register 0x05 always reads 0x00.
- R4: Bit 0 of register 0x04 is the readback selector. With 0, reads of 0x0A and 0x0B return the active copy. With 1, they return the buffered copy.
- R5: `cp_current_o` equals the active 0x0A value when bit 7 of the active 0x0B is 1. Otherwise it equals `pin_cp_i`.
- R6: The fields of the active 0x0B are decoded as follows:
  - bit 3 = 1 forces `cp_mode_o` to 2'b00; otherwise `cp_mode_o` follows bits 5:4;
  - bit 6 drives `abl_manual_o`;
  - bit 2 drives `fb_neg_edge_o`;
  - bit 1 drives `ref_neg_edge_o`;
  - bit 0 drives `vco_mid_o`.
- R7: Register 0x00 reads back as follows:
  - bit 7 reads 0;
  - bit 6 reads the bit-order setting;
  - bit 5 reads 0;
  - bit 4 reads 1;
  - bits 3:0 repeat bits 7:4.
- R8: Bit 6 of 0x00 selects least-significant-first order. In that order the instruction and the data bytes are shifted least significant bit first. A change to the order applies from the next transaction.
- R9: The address steps after each data byte: +1 in most-significant-first order and -1 in least-significant-first order. Bytes beyond the instruction's count are not written, and `sdo_oe` stays low during them.
- R10: Writing 1 to bit 5 of 0x00 returns every register to its default when that data byte completes. This covers the buffered and active copies, the readback selector and the bit order.
- R11: Unused bits read as 0. Register 0x04 bits 7:1 read 0. Unimplemented addresses such as 0x07 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| pin_cp_i | input | 8 | Pin-derived charge-pump current code |
| cp_current_o | output | 8 | Selected charge-pump current code |
| cp_mode_o | output | 2 | Charge-pump mode (00 off, 01 up, 10 down, 11 normal) |
| fb_neg_edge_o | output | 1 | Feedback input uses the falling edge |
| ref_neg_edge_o | output | 1 | Reference input uses the falling edge |
| vco_mid_o | output | 1 | Hold the oscillator control at midscale |
| abl_manual_o | output | 1 | Anti-backlash period under register control |

## Verification
A corrupt buffer or active copy becomes visible in one of two ways. The decoded outputs show it right after the next update write. A readback shows it within one transaction once the selector points at that copy. A wrong bit-order latch or address step garbles every byte after the instruction of the next transaction. It also shifts the data onto a neighbouring register. A stuck update or soft-reset path leaves the outputs at old values after the byte that should have moved them. A fault in the count window shows as a write to the wrong register, or as `sdo_oe` held high past the last counted byte.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int DW      = 8;
  localparam int AW      = 13;
  localparam int INSTR_W = 16;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam int NBUF    = 2;
  localparam int IDX_CUR = 0;
  localparam int IDX_CTL = 1;

  localparam logic [AW-1:0] ADR_CFG   = 13'h000;
  localparam logic [AW-1:0] ADR_RBSEL = 13'h004;
  localparam logic [AW-1:0] ADR_UPD   = 13'h005;
  localparam logic [AW-1:0] ADR_CPCUR = 13'h00A;
  localparam logic [AW-1:0] ADR_CPCTL = 13'h00B;

  // bit positions that downstream decode relies on
  localparam int CFG_ORDER_B = 6;
  localparam int CFG_SRST_B  = 5;
  localparam int CTL_OVR_B   = 7;
  localparam int CTL_ABL_B   = 6;
  localparam int CTL_OFF_B   = 3;
  localparam int CTL_FB_B    = 2;
  localparam int CTL_REF_B   = 1;
  localparam int CTL_VCO_B   = 0;

  function automatic logic [AW-1:0] buf_addr(input int i);
    return (i == IDX_CUR) ? ADR_CPCUR : ADR_CPCTL;
  endfunction

  function automatic logic [DW-1:0] buf_def(input int i);
    return (i == IDX_CUR) ? 8'h80 : 8'h30;
  endfunction
endpackage

// File: rtl/cfg_spi_front.sv
module cfg_spi_front
  import cfgbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          lsb_cfg,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          sdo_oe
);
  logic [2:0] sclk_s, cs_s;
  logic [1:0] sdi_s;
  logic sclk_rise, sclk_fall, cs_act, cs_start, sdi_b;

  logic [INSTR_W-1:0] sh_q, sh_d, sh_nx;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]      addr_q, addr_d, wa_q, wa_d;
  logic [DW-1:0]      wd_q, wd_d, byte_nx;
  logic [1:0]         left_q, left_d;
  logic lsb_q, lsb_d, dph_q, dph_d, rd_q, rd_d, live_q, live_d;
  logic we_q, we_d, sdo_q, sdo_d, oe_q, oe_d;
  logic [2:0] bidx;

  // input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= 3'b000;
      cs_s   <= 3'b111;
      sdi_s  <= 2'b00;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      cs_s   <= {cs_s[1:0], cs_n};
      sdi_s  <= {sdi_s[0], sdi};
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];
  assign sclk_fall = ~sclk_s[1] & sclk_s[2];
  assign cs_act    = ~cs_s[1];
  assign cs_start  = ~cs_s[1] & cs_s[2];
  assign sdi_b     = sdi_s[1];

  assign sh_nx   = lsb_q ? {sdi_b, sh_q[INSTR_W-1:1]} : {sh_q[INSTR_W-2:0], sdi_b};
  assign byte_nx = lsb_q ? sh_nx[INSTR_W-1:INSTR_W-DW] : sh_nx[DW-1:0];
  assign bidx    = lsb_q ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);

  always_comb begin
    sh_d = sh_q; cnt_d = cnt_q; addr_d = addr_q; wa_d = wa_q; wd_d = wd_q;
    left_d = left_q; lsb_d = lsb_q; dph_d = dph_q; rd_d = rd_q; live_d = live_q;
    we_d = 1'b0; sdo_d = sdo_q; oe_d = oe_q;
    if (!cs_act) begin
      cnt_d = '0; dph_d = 1'b0; live_d = 1'b0; oe_d = 1'b0; sdo_d = 1'b0;
    end else begin
      if (cs_start) lsb_d = lsb_cfg;
      if (sclk_rise) begin
        sh_d = sh_nx;
        if (!dph_q) begin
          if (cnt_q == CNT_W'(INSTR_W-1)) begin
            rd_d   = sh_nx[INSTR_W-1];
            left_d = sh_nx[INSTR_W-2:INSTR_W-3];
            addr_d = sh_nx[AW-1:0];
            dph_d  = 1'b1;
            live_d = 1'b1;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (cnt_q == CNT_W'(DW-1)) begin
          cnt_d  = '0;
          we_d   = live_q & ~rd_q;
          wa_d   = addr_q;
          wd_d   = byte_nx;
          addr_d = lsb_q ? addr_q - 1'b1 : addr_q + 1'b1;
          if (left_q == 2'd0) live_d = 1'b0;
          else left_d = left_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (sclk_fall) begin
        oe_d  = dph_q & rd_q & live_q;
        sdo_d = (dph_q & rd_q & live_q) ? rd_data[bidx] : 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; addr_q <= '0; wa_q <= '0; wd_q <= '0;
      left_q <= '0; lsb_q <= 1'b0; dph_q <= 1'b0; rd_q <= 1'b0; live_q <= 1'b0;
      we_q <= 1'b0; sdo_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d; cnt_q <= cnt_d; addr_q <= addr_d; wa_q <= wa_d; wd_q <= wd_d;
      left_q <= left_d; lsb_q <= lsb_d; dph_q <= dph_d; rd_q <= rd_d; live_q <= live_d;
      we_q <= we_d; sdo_q <= sdo_d; oe_q <= oe_d;
    end
  end

  assign rd_addr = addr_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;

  // R2: the data line is released whenever select is inactive
  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo_oe);
  // R2: byte bit counter never leaves its range in the data phase
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dph_q |-> (cnt_q < CNT_W'(DW)));
  // R9: no write strobe once the count window has closed
  assert_no_write_past_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dph_q && !live_q) |=> !wr_en);
endmodule

// File: rtl/cfg_dbuf_cell.sv
module cfg_dbuf_cell #(
  parameter int W = 8,
  parameter logic [W-1:0] DEF = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] buf_q, buf_d, act_q, act_d;
  logic buf_en, act_en;

  assign buf_en = srst | wr;
  assign act_en = srst | upd;

  always_comb begin
    buf_d = srst ? DEF : wdata;
    act_d = srst ? DEF : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= DEF;
      act_q <= DEF;
    end else begin
      if (buf_en) buf_q <= buf_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;

  // R3: active copy holds unless an update or soft reset is applied
  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !upd) |=> $stable(act_o));
  // R3: an update makes the active copy equal the buffer it sampled
  assert_update_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !srst) |=> (act_o == $past(buf_o)));
  // R10: soft reset returns both copies to the default
  assert_srst_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (act_o == DEF && buf_o == DEF));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfgbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     lsb_cfg,
  output logic [NBUF-1:0][DW-1:0]  act_o
);
  logic wr_cfg, srst, upd, wr_rb;
  logic lsb_q, lsb_d, rbsel_q, rbsel_d;
  logic [NBUF-1:0][DW-1:0] buf_v;
  logic [3:0] cfg_hi;

  assign wr_cfg = wr_en && (wr_addr == ADR_CFG);
  assign srst   = wr_cfg && wr_data[CFG_SRST_B];
  assign upd    = wr_en && (wr_addr == ADR_UPD) && wr_data[0];
  assign wr_rb  = wr_en && (wr_addr == ADR_RBSEL);

  for (genvar g = 0; g < NBUF; g++) begin : g_cell
    cfg_dbuf_cell #(.W(DW), .DEF(buf_def(g))) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .wr    (wr_en && (wr_addr == buf_addr(g))),
      .wdata (wr_data),
      .upd   (upd),
      .buf_o (buf_v[g]),
      .act_o (act_o[g])
    );
  end

  always_comb begin
    lsb_d   = lsb_q;
    rbsel_d = rbsel_q;
    if (srst) begin
      lsb_d   = 1'b0;
      rbsel_d = 1'b0;
    end else begin
      if (wr_cfg) lsb_d = wr_data[CFG_ORDER_B];
      if (wr_rb)  rbsel_d = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q   <= 1'b0;
      rbsel_q <= 1'b0;
    end else begin
      lsb_q   <= lsb_d;
      rbsel_q <= rbsel_d;
    end
  end

  assign cfg_hi = {1'b0, lsb_q, 1'b0, 1'b1};

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADR_CFG)   rd_data = {cfg_hi, cfg_hi};
    if (rd_addr == ADR_RBSEL) rd_data = {7'b0, rbsel_q};
    for (int i = 0; i < NBUF; i++) begin
      if (rd_addr == buf_addr(i)) rd_data = rbsel_q ? buf_v[i] : act_o[i];
    end
  end

  assign lsb_cfg = lsb_q;

  // R3: the update register never reads back as set
  assert_upd_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADR_UPD) |-> (rd_data == '0));
  // R10: soft reset clears the order and readback selections
  assert_srst_clears_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!lsb_cfg && !rbsel_q));
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import cfgbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic [DW-1:0] pin_cp_i,
  output logic [DW-1:0] cp_current_o,
  output logic [1:0]    cp_mode_o,
  output logic          fb_neg_edge_o,
  output logic          ref_neg_edge_o,
  output logic          vco_mid_o,
  output logic          abl_manual_o
);
  logic [1:0] rs_q;
  logic rst_sync_n;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data, ctl;
  logic wr_en, lsb_cfg;
  logic [NBUF-1:0][DW-1:0] act;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  cfg_spi_front u_front (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .sdi     (sdi),
    .lsb_cfg (lsb_cfg),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );

  cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .lsb_cfg (lsb_cfg),
    .act_o   (act)
  );

  assign ctl            = act[IDX_CTL];
  assign cp_current_o   = ctl[CTL_OVR_B] ? act[IDX_CUR] : pin_cp_i;
  assign cp_mode_o      = ctl[CTL_OFF_B] ? 2'b00 : ctl[5:4];
  assign abl_manual_o   = ctl[CTL_ABL_B];
  assign fb_neg_edge_o  = ctl[CTL_FB_B];
  assign ref_neg_edge_o = ctl[CTL_REF_B];
  assign vco_mid_o      = ctl[CTL_VCO_B];

  // R6: a disabled pump never reports an active mode
  assert_pump_off_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl[CTL_OFF_B] |-> (cp_mode_o == 2'b00));
  // R5: without override the current code tracks the pin value
  assert_pin_current_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctl[CTL_OVR_B] |-> (cp_current_o == pin_cp_i));
endmodule

// File: tb/spi_cfg_bank_tb.sv
module spi_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n, sclk, cs_n, sdi, sdo, sdo_oe;
  logic [7:0] pin_cp, cp_cur;
  logic [1:0] cp_mode;
  logic fb_ne, ref_ne, vco_mid, abl_man;

  int checks = 0, errors = 0;
  bit done = 1'b0, tb_lsb = 1'b0;
  logic [7:0] wq [3];
  logic [7:0] rq [3];
  bit oeq [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .pin_cp_i(pin_cp), .cp_current_o(cp_cur),
    .cp_mode_o(cp_mode), .fb_neg_edge_o(fb_ne), .ref_neg_edge_o(ref_ne),
    .vco_mid_o(vco_mid), .abl_manual_o(abl_man)
  );

  // row: {ctl, cur, pin, exp_cur, exp_mode, exp {abl,fb,ref,vco}}
  localparam logic [37:0] VEC [6] = '{
    {8'h30, 8'h80, 8'h11, 8'h11, 2'd3, 4'b0000},
    {8'hB0, 8'h5A, 8'h11, 8'h5A, 2'd3, 4'b0000},
    {8'h38, 8'h22, 8'h33, 8'h33, 2'd0, 4'b0000},
    {8'h97, 8'hC3, 8'h33, 8'hC3, 2'd1, 4'b0111},
    {8'h6A, 8'h01, 8'h44, 8'h44, 2'd0, 4'b1010},
    {8'hE0, 8'hFF, 8'h00, 8'hFF, 2'd2, 4'b1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, output logic got, output logic oe);
    sdi = v;
    tick(HP);
    got = sdo;
    oe = sdo_oe;
    sclk = 1'b1;
    tick(HP);
    sclk = 1'b0;
  endtask

  // nbytes clocked, cntf = count field written into the instruction
  task automatic xfer(input bit rd, input logic [1:0] cntf, input logic [12:0] a, input int nbytes);
    logic [15:0] word;
    logic g, o;
    word = {rd, cntf, a};
    cs_n = 1'b0;
    tick(HP);
    for (int i = 0; i < 16; i++) send_bit(tb_lsb ? word[i] : word[15-i], g, o);
    for (int b = 0; b < nbytes; b++) begin
      oeq[b] = 1'b0;
      for (int i = 0; i < 8; i++) begin
        int idx;
        idx = tb_lsb ? i : 7 - i;
        send_bit(wq[b][idx], g, o);
        rq[b][idx] = g;
        oeq[b] = oeq[b] | o;
      end
    end
    tick(HP);
    cs_n = 1'b1;
    tick(3*HP);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    wq[0] = d;
    xfer(1'b0, 2'd0, a, 1);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    wq[0] = 8'h00;
    xfer(1'b1, 2'd0, a, 1);
    d = rq[0];
  endtask

  initial begin
    tick(150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [1:0] pmode;
    logic [3:0] pbits;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; pin_cp = 8'h11;
    tick(10);
    rst_n = 1'b1;
    tick(10);

    // R1 reset state
    chk("R1 cp_current", cp_cur, 8'h11);
    chk("R1 cp_mode", cp_mode, 2'd3);
    chk("R1 flags", {abl_man, fb_ne, ref_ne, vco_mid}, 4'b0000);
    chk("R2 sdo_oe idle", sdo_oe, 1'b0);
    rd1(13'h000, r); chk("R7 cfg default read", r, 8'h11);
    rd1(13'h00A, r); chk("R1 0x0A default", r, 8'h80);
    rd1(13'h00B, r); chk("R1 0x0B default", r, 8'h30);
    rd1(13'h004, r); chk("R4 selector default", r, 8'h00);

    // table: buffered write, hold check, update, decode check
    pmode = 2'd3; pbits = 4'b0000;
    for (int k = 0; k < 6; k++) begin
      logic [37:0] v;
      v = VEC[k];
      pin_cp = v[21:14];
      wq[0] = v[29:22]; wq[1] = v[37:30];
      xfer(1'b0, 2'd1, 13'h00A, 2);
      chk("R3 mode held before update", cp_mode, pmode);
      chk("R3 flags held before update", {abl_man, fb_ne, ref_ne, vco_mid}, pbits);
      wr1(13'h005, 8'h01);
      chk("R5 cp_current after update", cp_cur, v[13:6]);
      chk("R6 cp_mode decode", cp_mode, v[5:4]);
      chk("R6 flag decode", {abl_man, fb_ne, ref_ne, vco_mid}, v[3:0]);
      pmode = v[5:4]; pbits = v[3:0];
    end
    rd1(13'h005, r); chk("R3 update bit self-clears", r, 8'h00);

    // R4 readback selector
    wr1(13'h00A, 8'h99);
    rd1(13'h00A, r); chk("R4 active readback", r, 8'hFF);
    chk("R3 buffered write no effect", cp_cur, 8'hFF);
    wr1(13'h004, 8'hFF);
    rd1(13'h004, r); chk("R11 selector unused bits", r, 8'h01);
    rd1(13'h00A, r); chk("R4 buffered readback", r, 8'h99);

    // R11 unimplemented address
    wr1(13'h007, 8'hAA);
    rd1(13'h007, r); chk("R11 unimplemented reads 0", r, 8'h00);

    // R9 count window and address increment
    wq[0] = 8'h21; wq[1] = 8'h43;
    xfer(1'b0, 2'd0, 13'h00A, 2);
    rd1(13'h00B, r); chk("R9 byte past count not written", r, 8'hE0);
    wq[0] = 8'h00; wq[1] = 8'h00;
    xfer(1'b1, 2'd0, 13'h00A, 2);
    chk("R9 first read byte", rq[0], 8'h21);
    chk("R9 oe during counted byte", oeq[0], 1'b1);
    chk("R9 oe low past count", oeq[1], 1'b0);
    xfer(1'b1, 2'd1, 13'h00A, 2);
    chk("R9 msb-first read addr+1", rq[1], 8'hE0);

    // R8 least-significant-first order
    wr1(13'h000, 8'h40);
    tb_lsb = 1'b1;
    rd1(13'h000, r); chk("R8 R7 cfg read in lsb order", r, 8'h55);
    wq[0] = 8'h97; wq[1] = 8'h3C;
    xfer(1'b0, 2'd1, 13'h00B, 2);
    rd1(13'h00B, r); chk("R8 lsb write first byte", r, 8'h97);
    rd1(13'h00A, r); chk("R9 lsb write addr-1", r, 8'h3C);
    wq[0] = 8'h00; wq[1] = 8'h00;
    xfer(1'b1, 2'd1, 13'h00B, 2);
    chk("R8 lsb read byte0", rq[0], 8'h97);
    chk("R9 lsb read addr-1", rq[1], 8'h3C);
    wr1(13'h005, 8'h01);
    chk("R8 cp_current after lsb update", cp_cur, 8'h3C);
    chk("R8 cp_mode after lsb update", cp_mode, 2'd1);
    chk("R8 flags after lsb update", {abl_man, fb_ne, ref_ne, vco_mid}, 4'b0111);

    // R10 soft reset
    pin_cp = 8'h5E;
    wr1(13'h000, 8'h20);
    tb_lsb = 1'b0;
    chk("R10 cp_current back to pin", cp_cur, 8'h5E);
    chk("R10 cp_mode default", cp_mode, 2'd3);
    chk("R10 flags default", {abl_man, fb_ne, ref_ne, vco_mid}, 4'b0000);
    rd1(13'h000, r); chk("R10 order back to msb first", r, 8'h11);
    rd1(13'h004, r); chk("R10 selector default", r, 8'h00);
    wr1(13'h004, 8'h01);
    rd1(13'h00A, r); chk("R10 buffer default", r, 8'h80);
    rd1(13'h00B, r); chk("R10 control buffer default", r, 8'h30);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule